// File: doc/BRIEF.md
# Frame-Checked Pixel Stream Packer

This block sits between a pixel processing pipeline and a write-side FIFO whose reader may stop draining for long stretches. It turns a stream of pixel beats into tagged words: a frame header word before the first pixel of each image, a line header word before the first pixel of each line, and plain pixel words in between. The receiver can therefore check every image for completeness from the words alone.

When the FIFO fills part way through an image, the block does not simply lose the pixels that do not fit. It gives up on the whole image and writes a single abort word once space returns. It then consumes and throws away input beats until the next image starts. An image whose first beat meets a full FIFO is skipped entirely. Every skipped or aborted image adds one to a saturating drop counter. Frame header numbers keep advancing over skipped images, so the receiver also sees the gaps.

The input is a valid/ready stream. A beat is transferred in a cycle where both `in_valid` and `in_ready` are high. The block lowers `in_ready` while it writes header words ahead of a beat, or while its own write is blocked by `fifo_full`. A producer must hold a beat and its flags stable until the beat is taken. The FIFO side is a plain write strobe gated by the full flag.

Top module: `pixel_frame_packer`

## Requirements
- R1: An input beat is taken only in a cycle with `in_valid` and `in_ready` both high; `in_ready` is low whenever `in_valid` is low.
- R2: A frame header word carries tag 0xF in its top 4 bits and, below that, a frame number. The frame number starts at 0 after reset and goes up by one, modulo 2^(DATA_W-4), for every frame-start beat offered, whether that frame is kept or dropped. The header is written only while a frame-start beat is presented, and comes ahead of that beat's line header and pixel.
- R3: A line header word carries tag 0xE and a line number. The frame-start beat opens line 0, and each later beat with `in_sol` opens the next line. The line header comes directly after the frame header, or before the pixel of an `in_sol` beat.
- R4: A pixel word carries tag 0x0 in its top 4 bits and the input pixel in the bits below. The input beat is taken in the same cycle as its pixel word is written.
- R5: `fifo_wr` is never high in a cycle where `fifo_full` is high.
- R6: A frame-start beat that meets `fifo_full` high, arriving when no frame is in progress or at a beat boundary of a running frame, is taken and discarded. That frame is dropped, with no abort word, and every later beat of it is discarded.
- R7: When a running frame needs to write a header or pixel word and `fifo_full` is high, the frame is aborted. The block writes one abort word (tag 0xD, lower bits zero) in the first cycle the FIFO has space. From the abort until the next frame start it writes nothing else. Non-start beats arriving in that time are taken and discarded. A frame-start beat is held until the abort word has been written.
- R8: After reset, beats are taken and discarded without any write until the first frame-start beat.
- R9: `drop_count` adds one for each dropped or aborted frame, never steps by more than one per cycle, and stops at its all-ones value.
- R10: An active-low reset clears the drop count, the frame and line numbers, and any frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block takes the beat this cycle |
| in_pix | input | DATA_W-4 | Pixel value of the beat |
| in_sof | input | 1 | Beat is the first pixel of an image |
| in_sol | input | 1 | Beat is the first pixel of a line |
| fifo_full | input | 1 | Downstream FIFO has no free word |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_data | output | DATA_W | Tagged word to the FIFO |
| drop_count | output | DROP_W | Saturating count of lost frames |

## Verification
The bench builds the block with DATA_W = 8 and DROP_W = 4. This shrinks the frame and line numbers to 4 bits, so the frame number wraps after sixteen frame starts. The drop counter tops out at 15 within a short burst of skipped frames. Both the wrap and the saturation are therefore checked directly instead of being left untested at the 12-bit and 16-bit defaults.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int TAG_W = 4;

  localparam logic [TAG_W-1:0] TAG_FRAME = 4'hF;
  localparam logic [TAG_W-1:0] TAG_LINE  = 4'hE;
  localparam logic [TAG_W-1:0] TAG_ABORT = 4'hD;
  localparam logic [TAG_W-1:0] TAG_PIXEL = 4'h0;

  // Frame-level state of the packer
  typedef enum logic [1:0] {
    M_SEEK  = 2'd0,  // no frame in progress, waiting for a frame start
    M_PASS  = 2'd1,  // frame accepted, words flow to the FIFO
    M_ABORT = 2'd2   // frame lost, abort word still owed
  } mode_e;

  // Position within the current beat while in M_PASS
  typedef enum logic [1:0] {
    P_HEAD = 2'd0,   // nothing written yet for this beat
    P_LINE = 2'd1,   // frame header written, line header next
    P_PIX  = 2'd2    // headers done, pixel next
  } phase_e;

  typedef enum logic [2:0] {
    W_NONE  = 3'd0,
    W_FRAME = 3'd1,
    W_LINE  = 3'd2,
    W_PIXEL = 3'd3,
    W_ABORT = 3'd4
  } word_e;
endpackage

// File: rtl/pfp_sat_counter.sv
module pfp_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/pfp_index.sv
module pfp_index #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ev,
  input  logic             line_ev,
  output logic [IDX_W-1:0] frame_idx,
  output logic [IDX_W-1:0] line_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_idx <= '0;
      line_idx  <= '0;
    end else begin
      if (frame_ev) frame_idx <= frame_idx + 1'b1;
      if (frame_ev)     line_idx <= '0;
      else if (line_ev) line_idx <= line_idx + 1'b1;
    end
  end
endmodule

// File: rtl/pfp_ctrl.sv
module pfp_ctrl
  import pfp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  logic  in_sof,
  input  logic  in_sol,
  input  logic  fifo_full,
  output logic  in_ready,
  output word_e wsel,
  output logic  frame_ev,
  output logic  line_ev,
  output logic  drop_ev
);
  mode_e  mode, mode_n;
  phase_e ph, ph_n;
  word_e  want;

  always_comb begin
    if (ph == P_LINE)     want = W_LINE;
    else if (ph == P_PIX) want = W_PIXEL;
    else if (in_sof)      want = W_FRAME;
    else if (in_sol)      want = W_LINE;
    else                  want = W_PIXEL;
  end

  always_comb begin
    mode_n   = mode;
    ph_n     = ph;
    wsel     = W_NONE;
    in_ready = 1'b0;
    frame_ev = 1'b0;
    line_ev  = 1'b0;
    drop_ev  = 1'b0;
    case (mode)
      M_SEEK: begin
        if (in_valid) begin
          if (!in_sof) begin
            in_ready = 1'b1;
          end else if (fifo_full) begin
            in_ready = 1'b1;
            drop_ev  = 1'b1;
            frame_ev = 1'b1;
          end else begin
            wsel     = W_FRAME;
            frame_ev = 1'b1;
            mode_n   = M_PASS;
            ph_n     = P_LINE;
          end
        end
      end
      M_PASS: begin
        if (in_valid) begin
          if (fifo_full) begin
            drop_ev = 1'b1;
            if (ph == P_HEAD && in_sof) begin
              in_ready = 1'b1;
              frame_ev = 1'b1;
              mode_n   = M_SEEK;
            end else begin
              mode_n = M_ABORT;
              ph_n   = P_HEAD;
            end
          end else begin
            wsel = want;
            case (want)
              W_FRAME: begin frame_ev = 1'b1; ph_n = P_LINE; end
              W_LINE:  begin line_ev  = 1'b1; ph_n = P_PIX;  end
              default: begin in_ready = 1'b1; ph_n = P_HEAD; end
            endcase
          end
        end
      end
      M_ABORT: begin
        in_ready = in_valid && !in_sof;
        if (!fifo_full) begin
          wsel   = W_ABORT;
          mode_n = M_SEEK;
        end
      end
      default: mode_n = M_SEEK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_SEEK;
      ph   <= P_HEAD;
    end else begin
      mode <= mode_n;
      ph   <= ph_n;
    end
  end
endmodule

// File: rtl/pixel_frame_packer.sv
module pixel_frame_packer
  import pfp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DROP_W = 16,
  localparam int PIX_W = DATA_W - TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic [DROP_W-1:0] drop_count
);
  word_e            wsel;
  logic             frame_ev, line_ev, drop_ev;
  logic [PIX_W-1:0] frame_idx, line_idx;

  pfp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_sol    (in_sol),
    .fifo_full (fifo_full),
    .in_ready  (in_ready),
    .wsel      (wsel),
    .frame_ev  (frame_ev),
    .line_ev   (line_ev),
    .drop_ev   (drop_ev)
  );

  pfp_index #(.IDX_W(PIX_W)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_ev  (frame_ev),
    .line_ev   (line_ev),
    .frame_idx (frame_idx),
    .line_idx  (line_idx)
  );

  pfp_sat_counter #(.W(DROP_W)) u_drops (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_ev),
    .count (drop_count)
  );

  always_comb begin
    case (wsel)
      W_FRAME: fifo_data = {TAG_FRAME, frame_idx};
      W_LINE:  fifo_data = {TAG_LINE, line_idx};
      W_PIXEL: fifo_data = {TAG_PIXEL, in_pix};
      W_ABORT: fifo_data = {TAG_ABORT, {PIX_W{1'b0}}};
      default: fifo_data = '0;
    endcase
  end

  assign fifo_wr = (wsel != W_NONE);
endmodule

// File: rtl/pfp_checker.sv
module pfp_checker
  import pfp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic              fifo_full,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic [DROP_W-1:0] drop_count
);
  logic [TAG_W-1:0] tag;
  assign tag = fifo_data[DATA_W-1 -: TAG_W];

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid); // R1

  AST_FRAME_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == TAG_FRAME) |-> (in_valid && in_sof)); // R2

  AST_LINE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == TAG_FRAME) |=> (!fifo_wr || tag == TAG_LINE)); // R3

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full); // R5

  AST_QUIET_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == TAG_ABORT) |=> !(fifo_wr && tag != TAG_FRAME)); // R7

  AST_DROP_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1)); // R9
endmodule

bind pixel_frame_packer pfp_checker #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_pfp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sof     (in_sof),
  .fifo_full  (fifo_full),
  .fifo_wr    (fifo_wr),
  .fifo_data  (fifo_data),
  .drop_count (drop_count)
);

// File: tb/pixel_frame_packer_bench.sv
`timescale 1ns/1ps
module pixel_frame_packer_bench;
  localparam int DATA_W = 8;
  localparam int DROP_W = 4;
  localparam int PIX_W  = DATA_W - 4;
  localparam int IDXM   = 1 << PIX_W;
  localparam int NROW   = 22;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, fifo_full = 1'b0;
  logic [PIX_W-1:0]  in_pix = '0;
  logic              in_ready, fifo_wr;
  logic [DATA_W-1:0] fifo_data;
  logic [DROP_W-1:0] drop_count;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pixel_frame_packer #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_pixel_frame_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .in_sol(in_sol), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .drop_count(drop_count)
  );

  // Row: {valid, sof, sol, full, pix[4], exp_wr, exp_data[8], exp_ready, exp_drop[4]}
  localparam logic [21:0] TBL [0:NROW-1] = '{
    {1'b1,1'b0,1'b0,1'b0,4'h5, 1'b0,8'h00,1'b1,4'd0}, // 0  R8 discard before first frame
    {1'b1,1'b1,1'b1,1'b0,4'h3, 1'b1,8'hF0,1'b0,4'd0}, // 1  R2 frame 0 header
    {1'b1,1'b1,1'b1,1'b0,4'h3, 1'b1,8'hE0,1'b0,4'd0}, // 2  R3 line 0 header
    {1'b1,1'b1,1'b1,1'b0,4'h3, 1'b1,8'h03,1'b1,4'd0}, // 3  R4 pixel
    {1'b1,1'b0,1'b0,1'b0,4'h7, 1'b1,8'h07,1'b1,4'd0}, // 4  R4 pixel
    {1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,8'h00,1'b0,4'd0}, // 5  R1 idle
    {1'b1,1'b0,1'b1,1'b0,4'h9, 1'b1,8'hE1,1'b0,4'd0}, // 6  R3 line 1
    {1'b1,1'b0,1'b1,1'b0,4'h9, 1'b1,8'h09,1'b1,4'd0}, // 7  R4
    {1'b1,1'b0,1'b0,1'b1,4'hA, 1'b0,8'h00,1'b0,4'd0}, // 8  R7 abort begins
    {1'b1,1'b0,1'b0,1'b1,4'hA, 1'b0,8'h00,1'b1,4'd1}, // 9  R7 discard while full
    {1'b1,1'b0,1'b0,1'b0,4'hB, 1'b1,8'hD0,1'b1,4'd1}, // 10 R7 abort word
    {1'b1,1'b1,1'b1,1'b1,4'h1, 1'b0,8'h00,1'b1,4'd1}, // 11 R6 start meets full
    {1'b1,1'b0,1'b1,1'b0,4'h2, 1'b0,8'h00,1'b1,4'd2}, // 12 R6 rest discarded
    {1'b1,1'b1,1'b1,1'b0,4'h4, 1'b1,8'hF2,1'b0,4'd2}, // 13 R2 number skips dropped one
    {1'b1,1'b1,1'b1,1'b1,4'h4, 1'b0,8'h00,1'b0,4'd2}, // 14 R7 full before line header
    {1'b1,1'b1,1'b1,1'b0,4'h6, 1'b1,8'hD0,1'b0,4'd3}, // 15 R7 start held behind abort
    {1'b1,1'b1,1'b1,1'b0,4'h6, 1'b1,8'hF3,1'b0,4'd3}, // 16 R2
    {1'b1,1'b1,1'b1,1'b0,4'h6, 1'b1,8'hE0,1'b0,4'd3}, // 17 R3
    {1'b1,1'b1,1'b1,1'b0,4'h6, 1'b1,8'h06,1'b1,4'd3}, // 18 R4
    {1'b1,1'b1,1'b1,1'b1,4'h8, 1'b0,8'h00,1'b1,4'd3}, // 19 R6 start at beat boundary, full
    {1'b1,1'b0,1'b0,1'b0,4'hC, 1'b0,8'h00,1'b1,4'd4}, // 20 R6 discard, R9 count
    {1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,8'h00,1'b0,4'd4}  // 21 R1
  };

  function automatic string row_req(input int r);
    case (r)
      0: return "R8";
      1, 13, 16: return "R2";
      2, 6, 17: return "R3";
      3, 4, 7, 18: return "R4";
      5, 21: return "R1";
      11, 12, 19, 20: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, let the combinational outputs settle
  task automatic drive(input logic v, input logic s, input logic l,
                       input logic f, input logic [PIX_W-1:0] p);
    @(negedge clk);
    in_valid = v; in_sof = s; in_sol = l; fifo_full = f; in_pix = p;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [21:0] row;
    int exp_drop;
    int exp_fidx;

    repeat (3) @(posedge clk);
    #1;
    check(drop_count == 0 && !fifo_wr && !in_ready, "R10", "reset state",
          {fifo_wr, in_ready, drop_count}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      row = TBL[r];
      drive(row[21], row[20], row[19], row[18], row[17:14]);
      check(fifo_wr == row[13] && in_ready == row[4] && drop_count == row[3:0]
            && (!row[13] || fifo_data == row[12:5]),
            row_req(r), $sformatf("table row %0d {wr,rdy,drop,data}", r),
            {fifo_wr, in_ready, drop_count, fifo_data},
            {row[13], row[4], row[3:0], row[12:5]});
    end

    // Saturation of the drop counter, no writes while full
    exp_drop = 4;
    exp_fidx = 5;
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h1);
      check(!fifo_wr && in_ready, "R5", "start beat under full",
            {fifo_wr, in_ready}, 32'd1);
      exp_drop = (exp_drop < 15) ? exp_drop + 1 : 15;
      exp_fidx = (exp_fidx + 1) % IDXM;
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
    check(drop_count == DROP_W'(exp_drop), "R9", "drop count saturated",
          drop_count, exp_drop);

    // Frame number wrap and consecutive line numbers
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h2);
    check(fifo_wr && fifo_data == {4'hF, PIX_W'(exp_fidx)}, "R2", "wrapped frame number",
          fifo_data, {4'hF, PIX_W'(exp_fidx)});
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h2);
    check(fifo_wr && fifo_data == 8'hE0, "R3", "line 0", fifo_data, 8'hE0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h2);
    check(fifo_wr && in_ready && fifo_data == 8'h02, "R4", "pixel", fifo_data, 8'h02);
    for (int ln = 1; ln < 3; ln++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b0, 4'hF);
      check(fifo_wr && !in_ready && fifo_data == {4'hE, PIX_W'(ln)}, "R3", "next line number",
            fifo_data, {4'hE, PIX_W'(ln)});
      drive(1'b1, 1'b0, 1'b1, 1'b0, 4'hF);
      check(fifo_wr && in_ready && fifo_data == 8'h0F, "R4", "line pixel", fifo_data, 8'h0F);
    end

    // Long stall mid-frame: nothing written while full, one abort word after
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, 4'h3);
      check(!fifo_wr, "R5", "stalled mid-frame", fifo_wr, 32'd0);
    end
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h3);
    check(fifo_wr && fifo_data == 8'hD0, "R7", "abort word after stall", fifo_data, 8'hD0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 4'h3);
    check(!fifo_wr && in_ready, "R7", "quiet after abort", {fifo_wr, in_ready}, 32'd1);
    check(drop_count == 4'd15, "R9", "count held at top", drop_count, 32'd15);

    // Reset in the middle of a frame
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
    rst_n = 1'b0;
    #1;
    check(drop_count == 0 && !fifo_wr, "R10", "reset clears count",
          {fifo_wr, drop_count}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 1'b0, 4'h4);
    check(!fifo_wr && in_ready, "R8", "discard after reset", {fifo_wr, in_ready}, 32'd1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h4);
    check(fifo_wr && fifo_data == 8'hF0, "R10", "frame number restarts", fifo_data, 8'hF0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h4);
    check(fifo_wr && fifo_data == 8'hE0, "R3", "line 0 after reset", fifo_data, 8'hE0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h4);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
    check(!in_ready && !fifo_wr, "R1", "idle has no ready", {in_ready, fifo_wr}, 32'd0);

    finish_run();
  end
endmodule